// File: doc/BRIEF.md
# Multichannel Slot Enable Controller

This block follows the word slots of a time-division serial frame that carries up to 128 channels and decides, slot by slot, whether the current word takes part in reception and whether it takes part in transmission. A frame-sync input restarts the slot count and a word-boundary strobe advances it, so the block runs in step with a separate serializer. That serializer uses the per-direction active flags for two purposes. It discards received words in inactive slots. It holds its data output disabled in inactive transmit slots.

The channels are grouped into blocks of 16 contiguous slots. Only two blocks per direction can be live at once. Two block-select fields per direction name those blocks, and a 32-bit enable mask per direction gives one enable bit to each of the 32 slots they cover. When the last slot of any block ends, the controller raises a one-cycle end-of-block interrupt and reports the number of the block that just finished. Software can then load new masks and selects before the next pair of blocks comes round.

Top module: `slot_enable_ctrl`

## Requirements
- R1: While `rstN` is low, `slotIdx` is 0 and `eobIrq` is 0, and both stay so in the first cycle after reset release.
- R2: A clock edge with `frameSync` high makes `slotIdx` 0 in the following cycle. This also applies when `wordStrobe` is high in the same cycle.
- R3: A clock edge with `wordStrobe` high and `frameSync` low advances `slotIdx` by one. Slot 127 wraps to 0.
- R4: Block number = `slotIdx[6:4]`, offset = `slotIdx[3:0]`. If the block equals the first select field (bits [2:0] of the select port), the slot-active output equals mask bit `offset`.
- R5: If the block equals the second select field (bits [5:3]) and not the first, the slot-active output equals mask bit `16 + offset`.
- R6: A slot whose block matches neither select field is inactive, whatever the mask holds.
- R7: When both select fields name the same block, the first field wins, so mask bits 16 to 31 have no effect on that block.
- R8: Receive activity depends only on `rxMask` and `rxBlkSel`. Transmit activity depends only on `txMask` and `txBlkSel`.
- R9: A clock edge with `wordStrobe` high while the offset is 15 sets `eobIrq` high for exactly the next cycle. In that cycle `eobBlk` holds the number of the block that ended. `eobIrq` is low at all other times.
- R10: A clock edge with both `frameSync` and `wordStrobe` low leaves `slotIdx` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Frame start, restarts the slot count |
| wordStrobe | input | 1 | End of the current word slot |
| rxMask | input | 32 | Receive enables: bits 0-15 first block, 16-31 second block |
| txMask | input | 32 | Transmit enables, same layout as rxMask |
| rxBlkSel | input | 6 | Receive block selects: [2:0] first, [5:3] second |
| txBlkSel | input | 6 | Transmit block selects: [2:0] first, [5:3] second |
| slotIdx | output | 7 | Current slot number in the frame |
| rxSlotActive | output | 1 | Current slot is received |
| txSlotActive | output | 1 | Current slot is transmitted (data output enable) |
| eobIrq | output | 1 | One-cycle end-of-block interrupt |
| eobBlk | output | 3 | Number of the block that just ended |

## Verification
The assertions assume that `frameSync` and `wordStrobe` are synchronous single-cycle strobes. They also assume that masks and select fields change only between word boundaries. Under these assumptions the activity flags of a slot are a fixed function of `slotIdx` and the configuration. The stimulus drives every strobe for one clock and changes the configuration only just after a frame sync. It sweeps all 64 pairs of receive select values, each over a full 128-slot frame, with distinct receive and transmit masks.

// File: rtl/slot_enable_pkg.sv
package slot_enable_pkg;
  typedef struct packed {
    logic clear;
    logic advance;
    logic blockEnd;
  } slot_strobe_t;
endpackage

// File: rtl/slot_window_decode.sv
module slot_window_decode #(
  parameter int BLK_SIZE = 16,
  parameter int WIN_BLKS = 2,
  parameter int BLK_W    = 3,
  parameter int OFF_W    = 4,
  localparam int MASK_W  = BLK_SIZE * WIN_BLKS
) (
  input  logic [BLK_W-1:0]          curBlk,
  input  logic [OFF_W-1:0]          curOff,
  input  logic [MASK_W-1:0]         enMask,
  input  logic [WIN_BLKS*BLK_W-1:0] blkSel,
  output logic                      active
);
  always_comb begin
    logic hit;
    hit    = 1'b0;
    active = 1'b0;
    // lower window wins when two selects name the same block
    for (int w = 0; w < WIN_BLKS; w++) begin
      if (!hit && blkSel[w*BLK_W +: BLK_W] == curBlk) begin
        hit    = 1'b1;
        active = enMask[w*BLK_SIZE + int'(curOff)];
      end
    end
  end
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import slot_enable_pkg::*;
(
  input  logic         frameSync,
  input  logic         wordStrobe,
  input  logic         offAtEnd,
  output slot_strobe_t strobes
);
  always_comb begin
    strobes.clear    = frameSync;
    strobes.advance  = wordStrobe && !frameSync;
    strobes.blockEnd = wordStrobe && offAtEnd;
  end
endmodule

// File: rtl/slot_dp.sv
module slot_dp
  import slot_enable_pkg::*;
#(
  parameter int NUM_CH   = 128,
  parameter int BLK_SIZE = 16,
  parameter int WIN_BLKS = 2,
  localparam int IDX_W   = $clog2(NUM_CH),
  localparam int OFF_W   = $clog2(BLK_SIZE),
  localparam int BLK_W   = IDX_W - OFF_W,
  localparam int MASK_W  = BLK_SIZE * WIN_BLKS,
  localparam int SEL_W   = WIN_BLKS * BLK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  slot_strobe_t      strobes,
  input  logic [MASK_W-1:0] rxMask,
  input  logic [MASK_W-1:0] txMask,
  input  logic [SEL_W-1:0]  rxBlkSel,
  input  logic [SEL_W-1:0]  txBlkSel,
  output logic              offAtEnd,
  output logic [IDX_W-1:0]  slotIdx,
  output logic              rxSlotActive,
  output logic              txSlotActive,
  output logic              eobIrq,
  output logic [BLK_W-1:0]  eobBlk
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_CH - 1);
  localparam logic [OFF_W-1:0] LAST_OFF  = OFF_W'(BLK_SIZE - 1);

  logic [BLK_W-1:0] curBlk;
  logic [OFF_W-1:0] curOff;

  assign curBlk   = slotIdx[IDX_W-1:OFF_W];
  assign curOff   = slotIdx[OFF_W-1:0];
  assign offAtEnd = (curOff == LAST_OFF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotIdx <= '0;
      eobIrq  <= 1'b0;
      eobBlk  <= '0;
    end else begin
      if (strobes.clear)
        slotIdx <= '0;
      else if (strobes.advance)
        slotIdx <= (slotIdx == LAST_SLOT) ? '0 : slotIdx + 1'b1;
      eobIrq <= strobes.blockEnd;
      if (strobes.blockEnd)
        eobBlk <= curBlk;
    end
  end

  logic [1:0] dirActive;
  for (genvar d = 0; d < 2; d++) begin : g_dir
    slot_window_decode #(
      .BLK_SIZE(BLK_SIZE), .WIN_BLKS(WIN_BLKS), .BLK_W(BLK_W), .OFF_W(OFF_W)
    ) u_dec (
      .curBlk (curBlk),
      .curOff (curOff),
      .enMask ((d == 0) ? rxMask : txMask),
      .blkSel ((d == 0) ? rxBlkSel : txBlkSel),
      .active (dirActive[d])
    );
  end

  assign rxSlotActive = dirActive[0];
  assign txSlotActive = dirActive[1];
endmodule

// File: rtl/slot_enable_ctrl.sv
module slot_enable_ctrl
  import slot_enable_pkg::*;
#(
  parameter int NUM_CH   = 128,
  parameter int BLK_SIZE = 16,
  parameter int WIN_BLKS = 2,
  localparam int IDX_W   = $clog2(NUM_CH),
  localparam int OFF_W   = $clog2(BLK_SIZE),
  localparam int BLK_W   = IDX_W - OFF_W,
  localparam int MASK_W  = BLK_SIZE * WIN_BLKS,
  localparam int SEL_W   = WIN_BLKS * BLK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic              wordStrobe,
  input  logic [MASK_W-1:0] rxMask,
  input  logic [MASK_W-1:0] txMask,
  input  logic [SEL_W-1:0]  rxBlkSel,
  input  logic [SEL_W-1:0]  txBlkSel,
  output logic [IDX_W-1:0]  slotIdx,
  output logic              rxSlotActive,
  output logic              txSlotActive,
  output logic              eobIrq,
  output logic [BLK_W-1:0]  eobBlk
);
  slot_strobe_t strobes;
  logic         offAtEnd;

  slot_ctrl u_ctrl (
    .frameSync (frameSync),
    .wordStrobe(wordStrobe),
    .offAtEnd  (offAtEnd),
    .strobes   (strobes)
  );

  slot_dp #(.NUM_CH(NUM_CH), .BLK_SIZE(BLK_SIZE), .WIN_BLKS(WIN_BLKS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .rxMask      (rxMask),
    .txMask      (txMask),
    .rxBlkSel    (rxBlkSel),
    .txBlkSel    (txBlkSel),
    .offAtEnd    (offAtEnd),
    .slotIdx     (slotIdx),
    .rxSlotActive(rxSlotActive),
    .txSlotActive(txSlotActive),
    .eobIrq      (eobIrq),
    .eobBlk      (eobBlk)
  );
endmodule

// File: rtl/slot_enable_chk.sv
module slot_enable_chk #(
  parameter int NUM_CH   = 128,
  parameter int BLK_SIZE = 16,
  parameter int WIN_BLKS = 2,
  localparam int IDX_W   = $clog2(NUM_CH),
  localparam int OFF_W   = $clog2(BLK_SIZE),
  localparam int BLK_W   = IDX_W - OFF_W,
  localparam int SEL_W   = WIN_BLKS * BLK_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameSync,
  input logic             wordStrobe,
  input logic [SEL_W-1:0] rxBlkSel,
  input logic [SEL_W-1:0] txBlkSel,
  input logic [IDX_W-1:0] slotIdx,
  input logic             rxSlotActive,
  input logic             txSlotActive,
  input logic             eobIrq,
  input logic [BLK_W-1:0] eobBlk
);
  function automatic logic selHit(logic [SEL_W-1:0] sel, logic [BLK_W-1:0] b);
    logic h;
    h = 1'b0;
    for (int w = 0; w < WIN_BLKS; w++)
      if (sel[w*BLK_W +: BLK_W] == b) h = 1'b1;
    return h;
  endfunction

  always_comb begin
    if (!rstN) begin
      assert_reset_state_R1: assert (slotIdx == '0 || $isunknown(slotIdx));
    end
  end

  assert_sync_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> slotIdx == '0);

  assert_strobe_advances_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wordStrobe && !frameSync) |=>
      slotIdx == (($past(slotIdx) == IDX_W'(NUM_CH - 1)) ? '0 : $past(slotIdx) + 1'b1));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!wordStrobe && !frameSync) |=> $stable(slotIdx));

  assert_rx_unselected_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxSlotActive |-> selHit(rxBlkSel, slotIdx[IDX_W-1:OFF_W]));

  assert_tx_unselected_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    txSlotActive |-> selHit(txBlkSel, slotIdx[IDX_W-1:OFF_W]));

  assert_eob_raised_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wordStrobe && slotIdx[OFF_W-1:0] == OFF_W'(BLK_SIZE - 1)) |=>
      (eobIrq && eobBlk == $past(slotIdx[IDX_W-1:OFF_W])));

  assert_eob_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    eobIrq |-> ($past(wordStrobe) && $past(slotIdx[OFF_W-1:0]) == OFF_W'(BLK_SIZE - 1)));
endmodule

bind slot_enable_ctrl slot_enable_chk #(
  .NUM_CH(NUM_CH), .BLK_SIZE(BLK_SIZE), .WIN_BLKS(WIN_BLKS)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .frameSync   (frameSync),
  .wordStrobe  (wordStrobe),
  .rxBlkSel    (rxBlkSel),
  .txBlkSel    (txBlkSel),
  .slotIdx     (slotIdx),
  .rxSlotActive(rxSlotActive),
  .txSlotActive(txSlotActive),
  .eobIrq      (eobIrq),
  .eobBlk      (eobBlk)
);

// File: tb/tb_slot_enable_ctrl.sv
module tb_slot_enable_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameSync = 1'b0;
  logic        wordStrobe = 1'b0;
  logic [31:0] rxMask = '0;
  logic [31:0] txMask = '0;
  logic [5:0]  rxBlkSel = '0;
  logic [5:0]  txBlkSel = '0;
  logic [6:0]  slotIdx;
  logic        rxSlotActive;
  logic        txSlotActive;
  logic        eobIrq;
  logic [2:0]  eobBlk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  slot_enable_ctrl dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .wordStrobe(wordStrobe),
    .rxMask(rxMask), .txMask(txMask), .rxBlkSel(rxBlkSel), .txBlkSel(txBlkSel),
    .slotIdx(slotIdx), .rxSlotActive(rxSlotActive), .txSlotActive(txSlotActive),
    .eobIrq(eobIrq), .eobBlk(eobBlk)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (slot %0d)", req, act, exp, slotIdx);
    end
  endtask

  function automatic int expAct(logic [31:0] m, logic [5:0] sel, int idx);
    int b = idx / 16;
    int o = idx % 16;
    if (b == int'(sel[2:0])) return int'(m[o]);
    if (b == int'(sel[5:3])) return int'(m[16 + o]);
    return 0;
  endfunction

  // one clock with the given strobes; outputs are stable 2 ns after the edge
  task automatic tick(bit fs, bit ws);
    frameSync  = fs;
    wordStrobe = ws;
    @(posedge clk);
    #2;
    frameSync  = 1'b0;
    wordStrobe = 1'b0;
  endtask

  task automatic checkSlot(int idx);
    check("R4/R5/R6/R7/R8 rx", int'(rxSlotActive), expAct(rxMask, rxBlkSel, idx));
    check("R4/R5/R6/R7/R8 tx", int'(txSlotActive), expAct(txMask, txBlkSel, idx));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset slot", int'(slotIdx), 0);
    check("R1 reset irq", int'(eobIrq), 0);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    check("R1 after release slot", int'(slotIdx), 0);
    check("R1 after release irq", int'(eobIrq), 0);

    for (int k = 0; k < 64; k++) begin
      tick(1'b1, 1'b0);
      rxBlkSel = 6'(k);
      txBlkSel = 6'((k * 5 + 3) % 64);
      rxMask = 32'h9E37_79B9 * 32'(k + 1);
      txMask = 32'h7F4A_7C15 ^ (rxMask << 3);
      #1;
      check("R2 sync to zero", int'(slotIdx), 0);
      checkSlot(0);
      for (int s = 1; s <= 128; s++) begin
        tick(1'b0, 1'b1);
        check("R3 advance", int'(slotIdx), s % 128);
        checkSlot(s % 128);
        check("R9 irq", int'(eobIrq), ((s - 1) % 16 == 15) ? 1 : 0);
        if ((s - 1) % 16 == 15) check("R9 block", int'(eobBlk), (s - 1) / 16);
      end
    end

    // idle hold, irq drop
    for (int s = 0; s < 37; s++) tick(1'b0, 1'b1);
    check("R3 at 37", int'(slotIdx), 37);
    tick(1'b0, 1'b0);
    check("R10 hold", int'(slotIdx), 37);
    check("R9 irq low when idle", int'(eobIrq), 0);
    tick(1'b1, 1'b1);
    check("R2 sync beats strobe", int'(slotIdx), 0);
    check("R9 no irq mid block", int'(eobIrq), 0);

    // sync together with strobe at the last slot of block 2
    for (int s = 0; s < 47; s++) tick(1'b0, 1'b1);
    check("R3 at 47", int'(slotIdx), 47);
    tick(1'b1, 1'b1);
    check("R2 sync at block end", int'(slotIdx), 0);
    check("R9 irq with sync", int'(eobIrq), 1);
    check("R9 block with sync", int'(eobBlk), 2);
    tick(1'b0, 1'b0);
    check("R9 single cycle", int'(eobIrq), 0);

    // R7: both selects on block 0, second half of mask must not matter
    rxBlkSel = 6'b000_000;
    rxMask   = 32'hFFFF_0000;
    #1;
    check("R7 first select wins", int'(rxSlotActive), 0);
    rxMask   = 32'h0000_0001;
    #1;
    check("R7 first select bit", int'(rxSlotActive), 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule